// File: doc/BRIEF.md
# Multi-Queue Shared Write Port

This block is the write side of a buffer memory that is shared by a number of logical queues behind a single write port. One data bus, one clock and one active-low write enable serve every queue. A separate select strobe, qualified by a queue address, names the queue that later writes go to. The port can take a word on every clock, including the clocks in which a queue change is in progress.

A queue change is pipelined over four clocks. A word written on the clock that carries the select strobe, or on any of the next three clocks, still goes to the queue that was active before. The new queue takes over from the fourth clock onward. Each queue owns an equal, fixed slice of an on-chip array, with its own write pointer, read pointer and fill count. One full flag shows the state of the queue that is currently active. Writes to a full queue are dropped. A plain per-queue read port exists so that queues can be drained.

Top module: `mqw_write_port`

## Requirements
- R1: After reset, queue 0 is active, every queue is empty, `full_flag` is 0 and `rd_valid` is 0.
- R2: A queue select is taken from `sel_addr` on a rising clock edge at which `sel_strobe` is 1. The level of `wr_en_n` has no effect on whether the select is taken.
- R3: A queue change takes four clocks. Enabled writes sampled on the select edge and on the next three edges go to the previously active queue. Writes from the fourth edge after the select edge onward go to the new queue.
- R4: Once a queue is active, every later enabled write goes to it until another select completes.
- R5: `wr_en_n` is active low. A word is stored only on an edge where `wr_en_n` is 0 and the active queue is not full. When `wr_en_n` is 1, nothing is stored.
- R6: `full_flag` is 1 exactly when the active queue holds DEPTH words. It switches to the new queue's state on the edge at which the change completes.
- R7: An enabled write to a full queue stores nothing. This also holds when the queue was already full at the moment it was selected.
- R8: Each queue keeps its own pointers and count. Returning to a queue appends after the words it already holds, and words come out in write order.
- R9: With `rd_req` at 1 and queue `rd_q` not empty, the next clock presents that queue's oldest word on `rd_data` with `rd_valid` at 1. A read of an empty queue gives `rd_valid` 0 and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both the write and the read side |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_data | input | DATA_W | Word to be written |
| wr_en_n | input | 1 | Write enable, active low |
| sel_strobe | input | 1 | Queue select strobe, active high |
| sel_addr | input | QW | Queue number taken with the strobe |
| full_flag | output | 1 | Active queue holds DEPTH words |
| rd_req | input | 1 | Read request for queue `rd_q` |
| rd_q | input | QW | Queue to read |
| rd_data | output | DATA_W | Oldest word of the queue that was read |
| rd_valid | output | 1 | `rd_data` holds a word read on the previous edge |

## Verification
The hardest case to reach from the ports is an enabled write that lands inside the four-clock switch window while the old queue or the new queue is at its limit. At that point the port's bookkeeping, the steering and the full flag all change on the same edge. A table of per-clock vectors keeps `wr_en_n` low through each window and arranges for the old queue to fill exactly on the committing edge. A later select then lands on a queue that is already full. Draining every queue afterwards shows where each word went and which words were dropped.

// File: rtl/mqw_pkg.sv
package mqw_pkg;

    localparam int MAX_QUEUES = 128;

    // Width of a pointer that walks a region of the given depth (never zero)
    function automatic int ptr_width(input int depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction

    // Width of a counter that can hold values 0..depth
    function automatic int cnt_width(input int depth);
        return $clog2(depth + 1);
    endfunction

endpackage

// File: rtl/mqw_sel_pipe.sv
// Queue-change pipeline: a select taken at edge A becomes active at edge A+LAT-1,
// so the first write steered to the new queue is sampled at edge A+LAT.
module mqw_sel_pipe #(
    parameter int LAT = 4,
    parameter int QW  = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel_strobe,
    input  logic [QW-1:0] sel_addr,
    output logic [QW-1:0] active_q
);
    localparam int NSTG = (LAT > 1) ? LAT - 1 : 1;

    typedef struct packed {
        logic          vld;
        logic [QW-1:0] qid;
    } stage_t;

    typedef struct packed {
        stage_t [NSTG-1:0] stg;
        logic [QW-1:0]     act;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.stg[0].vld = sel_strobe;
        st_d.stg[0].qid = sel_addr;
        for (int i = 1; i < NSTG; i++) begin
            st_d.stg[i] = st_q.stg[i-1];
        end
        if (st_q.stg[NSTG-1].vld) begin
            st_d.act = st_q.stg[NSTG-1].qid;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active_q = st_q.act;

endmodule

// File: rtl/mqw_occupancy.sv
// Per-queue pointers and fill counts; decides which writes and reads proceed.
module mqw_occupancy
    import mqw_pkg::*;
#(
    parameter int NQ    = 8,
    parameter int DEPTH = 4,
    parameter int QW    = 3,
    parameter int AW    = 5,
    parameter int CW    = cnt_width(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_req,
    input  logic [QW-1:0] active_q,
    input  logic          rd_req,
    input  logic [QW-1:0] rd_q,
    output logic          wr_go,
    output logic [AW-1:0] wr_addr,
    output logic          rd_go,
    output logic [AW-1:0] rd_addr,
    output logic          act_full,
    output logic [CW-1:0] act_cnt
);
    localparam int PW = ptr_width(DEPTH);
    localparam logic [PW-1:0] PTR_LAST = PW'(DEPTH - 1);
    localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);

    typedef struct packed {
        logic [PW-1:0] wp;
        logic [PW-1:0] rp;
        logic [CW-1:0] cnt;
    } qstate_t;

    qstate_t [NQ-1:0] qs_d, qs_q;

    logic [NQ-1:0] inc_vec, dec_vec;

    // One-hot steering of the accepted write and read, one lane per queue
    for (genvar g = 0; g < NQ; g++) begin : g_lane
        assign inc_vec[g] = wr_go && (int'(active_q) == g);
        assign dec_vec[g] = rd_go && (int'(rd_q) == g);
    end

    always_comb begin
        act_cnt  = qs_q[active_q].cnt;
        act_full = (act_cnt == CNT_FULL);
        wr_go    = wr_req && !act_full;
        rd_go    = rd_req && (qs_q[rd_q].cnt != '0);
        wr_addr  = AW'(int'(active_q) * DEPTH + int'(qs_q[active_q].wp));
        rd_addr  = AW'(int'(rd_q) * DEPTH + int'(qs_q[rd_q].rp));
    end

    always_comb begin
        qs_d = qs_q;
        for (int i = 0; i < NQ; i++) begin
            if (inc_vec[i]) begin
                qs_d[i].wp = (qs_q[i].wp == PTR_LAST) ? '0 : qs_q[i].wp + 1'b1;
            end
            if (dec_vec[i]) begin
                qs_d[i].rp = (qs_q[i].rp == PTR_LAST) ? '0 : qs_q[i].rp + 1'b1;
            end
            case ({inc_vec[i], dec_vec[i]})
                2'b10:   qs_d[i].cnt = qs_q[i].cnt + 1'b1;
                2'b01:   qs_d[i].cnt = qs_q[i].cnt - 1'b1;
                default: qs_d[i].cnt = qs_q[i].cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            qs_q <= '0;
        end else begin
            qs_q <= qs_d;
        end
    end

endmodule

// File: rtl/mqw_store.sv
// Shared word array with one write and one registered read.
module mqw_store #(
    parameter int DW      = 16,
    parameter int ENTRIES = 32,
    parameter int AW      = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata,
    output logic          rvalid
);
    typedef struct packed {
        logic [DW-1:0] data;
        logic          vld;
    } rd_state_t;

    logic [DW-1:0] mem [ENTRIES];
    rd_state_t     rs_d, rs_q;

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    always_comb begin
        rs_d     = rs_q;
        rs_d.vld = re;
        if (re) begin
            rs_d.data = mem[raddr];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rs_q <= '0;
        end else begin
            rs_q <= rs_d;
        end
    end

    assign rdata  = rs_q.data;
    assign rvalid = rs_q.vld;

endmodule

// File: rtl/mqw_write_port.sv
module mqw_write_port
    import mqw_pkg::*;
#(
    parameter int NUM_QUEUES = 8,
    parameter int DEPTH      = 4,
    parameter int DATA_W     = 16,
    parameter int SWITCH_LAT = 4,
    parameter int QW         = (NUM_QUEUES > 1) ? $clog2(NUM_QUEUES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_en_n,
    input  logic              sel_strobe,
    input  logic [QW-1:0]     sel_addr,
    output logic              full_flag,
    input  logic              rd_req,
    input  logic [QW-1:0]     rd_q,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    localparam int ENTRIES = NUM_QUEUES * DEPTH;
    localparam int AW      = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam int CW      = cnt_width(DEPTH);

    logic [QW-1:0] active_q;
    logic [CW-1:0] act_cnt;
    logic          wr_go, rd_go;
    logic [AW-1:0] wr_addr, rd_addr;

    mqw_sel_pipe #(
        .LAT (SWITCH_LAT),
        .QW  (QW)
    ) u_sel (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_strobe (sel_strobe),
        .sel_addr   (sel_addr),
        .active_q   (active_q)
    );

    mqw_occupancy #(
        .NQ    (NUM_QUEUES),
        .DEPTH (DEPTH),
        .QW    (QW),
        .AW    (AW),
        .CW    (CW)
    ) u_occ (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_req   (!wr_en_n),
        .active_q (active_q),
        .rd_req   (rd_req),
        .rd_q     (rd_q),
        .wr_go    (wr_go),
        .wr_addr  (wr_addr),
        .rd_go    (rd_go),
        .rd_addr  (rd_addr),
        .act_full (full_flag),
        .act_cnt  (act_cnt)
    );

    mqw_store #(
        .DW      (DATA_W),
        .ENTRIES (ENTRIES),
        .AW      (AW)
    ) u_mem (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (wr_go),
        .waddr  (wr_addr),
        .wdata  (wr_data),
        .re     (rd_go),
        .raddr  (rd_addr),
        .rdata  (rd_data),
        .rvalid (rd_valid)
    );

endmodule

// File: rtl/mqw_write_port_chk.sv
module mqw_write_port_chk #(
    parameter int DEPTH = 4,
    parameter int LAT   = 4,
    parameter int QW    = 3,
    parameter int CW    = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sel_strobe,
    input logic          wr_en_n,
    input logic          rd_req,
    input logic [QW-1:0] rd_q,
    input logic          full_flag,
    input logic          rd_valid,
    input logic [QW-1:0] active_q,
    input logic [CW-1:0] act_cnt
);
    // Strobe history kept by the checker itself: bit k set means a strobe k+1 edges ago
    logic [LAT-1:0] hist;
    logic           commit_now;
    logic           rd_hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist <= '0;
        end else begin
            hist <= {hist[LAT-2:0], sel_strobe};
        end
    end

    assign commit_now = hist[LAT-2];
    assign rd_hit     = rd_req && (rd_q == active_q);

    AST_RESET_STATE: assert property (@(posedge clk)
        $rose(rst_n) |-> (!full_flag && !rd_valid && active_q == '0)); // R1

    AST_SWITCH_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(active_q) |-> hist[LAT-1]); // R3

    AST_WRITE_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_n && !full_flag && !rd_hit && !commit_now)
        |=> (act_cnt == $past(act_cnt) + 1'b1)); // R5

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_n && !rd_hit && !commit_now) |=> $stable(act_cnt)); // R5

    AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (full_flag && !rd_hit && !commit_now) |=> (full_flag && $stable(act_cnt))); // R7

    always @(posedge clk) begin
        if (rst_n) begin
            AST_NO_OVERFLOW: assert (act_cnt <= CW'(DEPTH)); // R7
        end
    end

endmodule

bind mqw_write_port mqw_write_port_chk #(
    .DEPTH (DEPTH),
    .LAT   (SWITCH_LAT),
    .QW    (QW),
    .CW    (CW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_strobe (sel_strobe),
    .wr_en_n    (wr_en_n),
    .rd_req     (rd_req),
    .rd_q       (rd_q),
    .full_flag  (full_flag),
    .rd_valid   (rd_valid),
    .active_q   (active_q),
    .act_cnt    (act_cnt)
);

// File: tb/tb_mqw_write_port.sv
module tb_mqw_write_port;
    localparam int NQ  = 8;
    localparam int DEP = 4;
    localparam int DW  = 16;
    localparam int QW  = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          wr_en_n = 1'b1;
    logic          sel_strobe = 1'b0;
    logic [QW-1:0] sel_addr = '0;
    logic          full_flag;
    logic          rd_req = 1'b0;
    logic [QW-1:0] rd_q = '0;
    logic [DW-1:0] rd_data;
    logic          rd_valid;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    mqw_write_port #(
        .NUM_QUEUES (NQ),
        .DEPTH      (DEP),
        .DATA_W     (DW),
        .SWITCH_LAT (4)
    ) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_data    (wr_data),
        .wr_en_n    (wr_en_n),
        .sel_strobe (sel_strobe),
        .sel_addr   (sel_addr),
        .full_flag  (full_flag),
        .rd_req     (rd_req),
        .rd_q       (rd_q),
        .rd_data    (rd_data),
        .rd_valid   (rd_valid)
    );

    // Vector: 32'hS A W F DDDD = strobe, address, wr_en_n, expected full_flag after the edge, data
    localparam logic [31:0] VEC [16] = '{
        32'h0000_0010, // q0
        32'h1300_0011, // select q3 (edge A), word still to q0 (R3)
        32'h0000_0012, // q0
        32'h0010_0013, // disabled, dropped (R5)
        32'h0000_0014, // A+3: still q0, q0 now full; q3 active after
        32'h0000_0015, // first word to q3
        32'h1510_0016, // select q5 without a write (R2)
        32'h0000_0017, // q3
        32'h0000_0018, // q3
        32'h0000_0019, // A+3: q3, q3 full; q5 active after
        32'h0000_001A, // q5
        32'h1000_001B, // select q0, word to q5
        32'h0000_001C, // q5
        32'h0001_001D, // q5 full, flag shows q5
        32'h0001_001E, // A+3: q5 full, dropped (R7); q0 active and full (R6)
        32'h0001_001F  // q0 full at selection, dropped (R7)
    };

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one clock of write-side stimulus at a falling edge; return after the next falling edge
    task automatic wr_cycle(input logic s, input logic [QW-1:0] a, input logic wn, input logic [DW-1:0] d);
        sel_strobe = s;
        sel_addr   = a;
        wr_en_n    = wn;
        wr_data    = d;
        @(negedge clk);
        sel_strobe = 1'b0;
        wr_en_n    = 1'b1;
    endtask

    task automatic rd_expect(input logic [QW-1:0] q, input logic vld, input logic [DW-1:0] d, input string req);
        rd_req = 1'b1;
        rd_q   = q;
        @(negedge clk);
        rd_req = 1'b0;
        check(rd_valid == vld, req, 32'(rd_valid), 32'(vld));
        if (vld) check(rd_data == d, req, 32'(rd_data), 32'(d));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(full_flag == 1'b0, "R1", 32'(full_flag), 0);
        check(rd_valid == 1'b0, "R1", 32'(rd_valid), 0);
        rd_expect(3'd0, 1'b0, '0, "R1");
        rd_expect(3'd7, 1'b0, '0, "R1");

        // Table walk: steering across switches, full flag after each edge (R2 R3 R6)
        for (int i = 0; i < 16; i++) begin
            wr_cycle(VEC[i][28], VEC[i][26:24], VEC[i][20], VEC[i][15:0]);
            check(full_flag == VEC[i][16], "R6", 32'(full_flag), 32'(VEC[i][16]));
        end

        // Drain: where each word landed (R3 R4 R5 R7 R9)
        rd_expect(3'd0, 1'b1, 16'h0010, "R4");
        rd_expect(3'd0, 1'b1, 16'h0011, "R3");
        rd_expect(3'd0, 1'b1, 16'h0012, "R5");
        rd_expect(3'd0, 1'b1, 16'h0014, "R3");
        rd_expect(3'd0, 1'b0, '0, "R7");
        check(full_flag == 1'b0, "R6", 32'(full_flag), 0);
        rd_expect(3'd3, 1'b1, 16'h0015, "R3");
        rd_expect(3'd3, 1'b1, 16'h0017, "R2");
        rd_expect(3'd3, 1'b1, 16'h0018, "R4");
        rd_expect(3'd3, 1'b1, 16'h0019, "R3");
        rd_expect(3'd3, 1'b0, '0, "R9");
        rd_expect(3'd5, 1'b1, 16'h001A, "R4");
        rd_expect(3'd5, 1'b1, 16'h001B, "R3");
        rd_expect(3'd5, 1'b1, 16'h001C, "R4");
        rd_expect(3'd5, 1'b1, 16'h001D, "R9");
        rd_expect(3'd5, 1'b0, '0, "R7");
        rd_expect(3'd1, 1'b0, '0, "R9");

        // R8: leave a queue with words in it and come back to it
        wr_cycle(1'b0, 3'd0, 1'b0, 16'h0021);
        wr_cycle(1'b0, 3'd0, 1'b0, 16'h0022);
        wr_cycle(1'b1, 3'd2, 1'b0, 16'h0023);
        repeat (3) wr_cycle(1'b0, 3'd0, 1'b1, 16'h0000);
        wr_cycle(1'b0, 3'd0, 1'b0, 16'h0024);
        check(full_flag == 1'b0, "R6", 32'(full_flag), 0);
        wr_cycle(1'b1, 3'd0, 1'b1, 16'h0000);
        repeat (3) wr_cycle(1'b0, 3'd0, 1'b1, 16'h0000);
        wr_cycle(1'b0, 3'd0, 1'b0, 16'h0025);
        check(full_flag == 1'b1, "R6", 32'(full_flag), 1);
        rd_expect(3'd0, 1'b1, 16'h0021, "R8");
        rd_expect(3'd0, 1'b1, 16'h0022, "R8");
        rd_expect(3'd0, 1'b1, 16'h0023, "R8");
        rd_expect(3'd0, 1'b1, 16'h0025, "R8");
        rd_expect(3'd2, 1'b1, 16'h0024, "R8");
        rd_expect(3'd2, 1'b0, '0, "R9");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule